// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a synthesizable synchronous static memory that lets reads and writes follow each other on every clock with no dead cycle between them. A command (load a new address or advance a running burst) is taken on a rising clock edge. For a write, the data and the per-lane write strobes arrive on the following enabled edge. For a read, the stored word flows combinationally from the array to the read port during the cycle after the command, with no output register in between. Because the data phase always trails the command phase by exactly one enabled clock, a read command can sit on the same edge as the data of an earlier write.

A load cycle sets a four-beat burst base from the address bus. Each later advance cycle moves to the next address of that group of four, in either a wrapping linear order or an XOR (interleaved) order that a mode pin selects. A clock-enable input stalls the whole block. Three chip selects allow a deselect. An asynchronous output enable and a sleep input gate the read port. The memory is split into independently writable byte lanes.

Top module: `ft_burst_sram`

## Requirements
- R1: A cycle with `clk_en_n` low, `advance` low, `cs_a_n` low, `cs_b` high, `cs_c_n` low and `wr_n` low is a write command; the `wdata` present on the next edge with `clk_en_n` low is stored at `addr`.
- R2: A load cycle with the same chip-select levels and `wr_n` high is a read command; in the cycle after its edge, `rdata` equals the stored word at that address and `rdata_oe` is 1 while `out_en_n` is 0 and `sleep` is 0.
- R3: Read and write commands may alternate on every enabled clock with no idle cycle, and a read issued on the edge that completes a write to the same address returns the new data.
- R4: `lane_wr_n[0]` guards bits 8:0 and `lane_wr_n[1]` guards bits 17:9, each sampled with the write data; a lane whose strobe is 1 keeps its old contents.
- R5: An edge with `clk_en_n` high changes no state: a pending read keeps the same output, and a pending write completes on the next enabled edge with the data present there.
- R6: A load cycle with any chip select inactive (`cs_a_n` high, `cs_b` low or `cs_c_n` high) performs no access, and `rdata_oe` is 0 in the following cycle.
- R7: With `burst_ilv` 0, the address bits 1:0 of beat k (k = 0..3) of a burst are (start + k) mod 4, and the upper address bits stay those of the load.
- R8: With `burst_ilv` 1, the address bits 1:0 of beat k are start XOR k.
- R9: While `out_en_n` is 1, `rdata_oe` is 0 and `rdata` is all zeros; writes are not affected by `out_en_n`.
- R10: While `sleep` is 1, `rdata_oe` is 0, and an enabled edge with `sleep` 1 starts no read or write.
- R11: After reset, no access is pending: `rdata_oe` is 0 and `rdata` is all zeros.
- R12: An advance cycle that follows a deselect (or any idle state) performs no access and drives no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| advance | input | 1 | 0 = load a new command, 1 = continue the current burst |
| wr_n | input | 1 | 0 = write, 1 = read, taken on load cycles |
| lane_wr_n | input | LANES | Active-low write strobe per byte lane, sampled with the data |
| addr | input | ADDR_W | Word address, taken on load cycles |
| burst_ilv | input | 1 | Burst order: 0 = linear wrap, 1 = interleaved |
| out_en_n | input | 1 | Asynchronous active-low read output enable |
| sleep | input | 1 | Low-power request; blocks new accesses and the read port |
| wdata | input | LANES*LANE_W | Write data, one enabled clock after the command |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High when `rdata` is driven (stands for a non-floating bus) |

## Verification
The bench builds the block with its default parameters: 6 address bits (64 words) and two 9-bit lanes. At that depth every word can be written and read back in a few hundred cycles. Bursts starting at each low-address phase cross the wrap of their four-word group. Addresses such as 8 to 11 show whether the upper address bits are kept through the burst. The two-lane split lets one strobe pattern per lane be tested against a known neighbour lane.

// File: rtl/ftb_pkg.sv
`timescale 1ns/1ps
package ftb_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // Low two address bits of beat number `step` in a burst starting at `start`.
   function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
      return ilv ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/ftb_burst_ctl.sv
`timescale 1ns/1ps
module ftb_burst_ctl
   import ftb_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              sel,
   input  logic              advance,
   input  logic              wr_n,
   input  logic              sleep,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] addr,
   output op_e               op_o,
   output logic [ADDR_W-1:0] acc_addr
);

   op_e               op_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else if (!cke_n) begin
         if (sleep) begin
            op_q <= OP_IDLE;
         end else if (!advance) begin
            if (sel) begin
               op_q   <= wr_n ? OP_READ : OP_WRITE;
               base_q <= addr;
               cnt_q  <= 2'd0;
            end else begin
               op_q <= OP_IDLE;
            end
         end else if (op_q != OP_IDLE) begin
            cnt_q <= cnt_q + 2'd1;
         end
      end
   end

   assign op_o     = op_q;
   assign acc_addr = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_q, ilv)};

   // R5: a stalled edge freezes the command pipeline
   p_stall_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(op_q) && $stable(base_q) && $stable(cnt_q)));

   // R7: a linear advance steps the low address by one and keeps the upper part
   p_lin_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && advance && !sleep && op_q != OP_IDLE && !ilv) |=>
      (ilv || ((acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1) &&
               (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])))));

   // R8: an interleaved advance moves the XOR distance from the base by one
   p_ilv_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && advance && !sleep && op_q != OP_IDLE && ilv) |=>
      (!ilv || ((acc_addr[1:0] ^ base_q[1:0]) ==
                (($past(acc_addr[1:0]) ^ $past(base_q[1:0])) + 2'd1))));

endmodule

// File: rtl/ftb_lane_array.sv
`timescale 1ns/1ps
module ftb_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && !lane_wr_n[l])
            cells[addr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = cells[addr];
   end

endmodule

// File: rtl/ft_burst_sram.sv
`timescale 1ns/1ps
module ft_burst_sram
   import ftb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    cs_a_n,
   input  logic                    cs_b,
   input  logic                    cs_c_n,
   input  logic                    advance,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    burst_ilv,
   input  logic                    out_en_n,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);

   localparam int DATA_W = LANES * LANE_W;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 16)
         else $fatal(1, "ADDR_W must lie in 2..16 (burst groups need two low bits)");
      assert (LANES >= 1 && LANE_W >= 1)
         else $fatal(1, "LANES and LANE_W must be positive");
   end

   logic              chip_sel;
   op_e               op;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] arr_rd;
   logic              arr_we;

   assign chip_sel = !cs_a_n && cs_b && !cs_c_n;

   ftb_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke_n    (clk_en_n),
      .sel      (chip_sel),
      .advance  (advance),
      .wr_n     (wr_n),
      .sleep    (sleep),
      .ilv      (burst_ilv),
      .addr     (addr),
      .op_o     (op),
      .acc_addr (acc_addr)
   );

   assign arr_we = !clk_en_n && (op == OP_WRITE);

   ftb_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
      .clk       (clk),
      .wr_en     (arr_we),
      .addr      (acc_addr),
      .lane_wr_n (lane_wr_n),
      .wdata     (wdata),
      .rdata     (arr_rd)
   );

   assign rdata_oe = (op == OP_READ) && !out_en_n && !sleep;
   assign rdata    = rdata_oe ? arr_rd : '0;

   // R6: a deselecting load leaves the read port undriven in the next cycle
   p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && !chip_sel) |=> !rdata_oe);

   // R10: an enabled edge taken in sleep starts no read
   p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && sleep) |=> !rdata_oe);

   // R5: read data held through a stall
   p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_n && rdata_oe) |=> (!rdata_oe || rdata == $past(rdata)));

endmodule

// File: tb/sim_ft_burst_sram.sv
`timescale 1ns/1ps
module sim_ft_burst_sram;

   localparam int AW = 6;
   localparam int DW = 18;
   localparam logic [2:0] ON  = 3'b010;   // {cs_a_n, cs_b, cs_c_n} all active
   localparam logic [2:0] OFF = 3'b110;   // cs_a_n inactive

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          cs_a_n = 1'b1, cs_b = 1'b1, cs_c_n = 1'b0;
   logic          advance = 1'b0, wr_n = 1'b1;
   logic [1:0]    lane_wr_n = 2'b00;
   logic [AW-1:0] addr = '0;
   logic          burst_ilv = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   always #4 clk = ~clk;

   ft_burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
      .cs_c_n(cs_c_n), .advance(advance), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
      .addr(addr), .burst_ilv(burst_ilv), .out_en_n(out_en_n), .sleep(sleep),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference model built from the requirements
   logic [DW-1:0] rmem [64];
   logic [1:0]    r_op = 2'd0;       // 0 idle, 1 read, 2 write
   logic [AW-1:0] r_base = '0;
   logic [1:0]    r_cnt = 2'd0;

   function automatic logic [AW-1:0] r_addr();
      logic [1:0] lo;
      lo = burst_ilv ? (r_base[1:0] ^ r_cnt) : (r_base[1:0] + r_cnt);
      return {r_base[AW-1:2], lo};
   endfunction

   function automatic logic [DW-1:0] fdat(input int a);
      return DW'(a * 4111) ^ 18'h15A5A;
   endfunction

   task automatic model_edge();
      if (!clk_en_n) begin
         if (r_op == 2'd2) begin
            if (!lane_wr_n[0]) rmem[r_addr()][8:0]  = wdata[8:0];
            if (!lane_wr_n[1]) rmem[r_addr()][17:9] = wdata[17:9];
         end
         if (sleep) r_op = 2'd0;
         else if (!advance) begin
            if (!cs_a_n && cs_b && !cs_c_n) begin
               r_op = wr_n ? 2'd1 : 2'd2; r_base = addr; r_cnt = 2'd0;
            end else r_op = 2'd0;
         end else if (r_op != 2'd0) r_cnt = r_cnt + 2'd1;
      end
   endtask

   task automatic compare(input string tag);
      logic          e_oe;
      logic [DW-1:0] e_d;
      e_oe = (r_op == 2'd1) && !out_en_n && !sleep;
      e_d  = e_oe ? rmem[r_addr()] : '0;
      n_chk++;
      if (rdata_oe !== e_oe || rdata !== e_d) begin
         n_bad++;
         $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h", tag, rdata_oe, rdata, e_oe, e_d);
      end
   endtask

   task automatic lit_check(input logic e_oe, input logic [DW-1:0] e_d, input string tag);
      n_chk++;
      if (rdata_oe !== e_oe || rdata !== e_d) begin
         n_bad++;
         $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h", tag, rdata_oe, rdata, e_oe, e_d);
      end
   endtask

   task automatic step(input logic c_n, input logic [2:0] cs, input logic adv, input logic wn,
                       input logic [AW-1:0] a, input logic [1:0] bw, input logic [DW-1:0] d,
                       input string tag);
      clk_en_n = c_n; {cs_a_n, cs_b, cs_c_n} = cs; advance = adv; wr_n = wn;
      addr = a; lane_wr_n = bw; wdata = d;
      #1;
      compare(tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   // {cke_n, selected, advance, wr_n, addr[5:0], lane_wr_n[1:0], wdata[17:0]}
   localparam logic [29:0] VEC [16] = '{
      {1'b0, 1'b1, 1'b0, 1'b0, 6'd3,  2'b00, 18'h00000},
      {1'b0, 1'b1, 1'b0, 1'b1, 6'd3,  2'b00, 18'h2AAAA},
      {1'b0, 1'b1, 1'b0, 1'b0, 6'd10, 2'b00, 18'h00000},
      {1'b0, 1'b1, 1'b0, 1'b1, 6'd11, 2'b00, 18'h1F0F0},
      {1'b0, 1'b1, 1'b0, 1'b0, 6'd11, 2'b00, 18'h3FFFF},
      {1'b0, 1'b1, 1'b1, 1'b0, 6'd0,  2'b00, 18'h05555},
      {1'b0, 1'b1, 1'b0, 1'b1, 6'd8,  2'b00, 18'h0ABCD},
      {1'b0, 1'b1, 1'b1, 1'b1, 6'd0,  2'b00, 18'h00000},
      {1'b1, 1'b1, 1'b0, 1'b0, 6'd33, 2'b00, 18'h12345},
      {1'b0, 1'b1, 1'b1, 1'b1, 6'd0,  2'b00, 18'h00000},
      {1'b0, 1'b1, 1'b0, 1'b0, 6'd20, 2'b00, 18'h00000},
      {1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  2'b10, 18'h3FFFF},
      {1'b0, 1'b1, 1'b0, 1'b1, 6'd20, 2'b00, 18'h00000},
      {1'b0, 1'b1, 1'b1, 1'b1, 6'd0,  2'b00, 18'h00000},
      {1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  2'b00, 18'h00000},
      {1'b0, 1'b1, 1'b1, 1'b0, 6'd0,  2'b00, 18'h2EEEE}
   };

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got no end, expected end of run");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) rmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      lit_check(1'b0, '0, "R11");
      @(negedge clk);

      // R1: back-to-back fill of every word, then R2: read every word back
      for (int a = 0; a < 64; a++)
         step(1'b0, ON, 1'b0, 1'b0, AW'(a), 2'b00, (a == 0) ? '0 : fdat(a - 1), "R1");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, fdat(63), "R1");
      for (int a = 0; a < 64; a++)
         step(1'b0, ON, 1'b0, 1'b1, AW'(a), 2'b00, '0, "R2");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, '0, "R2");

      // R3: mixed traffic table
      for (int i = 0; i < 16; i++) begin
         logic [29:0] v;
         v = VEC[i];
         step(v[29], v[28] ? ON : OFF, v[27], v[26], v[25:20], v[19:18], v[17:0], "R3");
      end
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, '0, "R3");

      // R7: linear write burst from 6 -> 6,7,4,5
      step(1'b0, ON, 1'b0, 1'b0, 6'd6, 2'b00, '0, "R7");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h00D00, "R7");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h00D01, "R7");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h00D02, "R7");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h00D03, "R7");
      step(1'b0, ON, 1'b0, 1'b1, 6'd4, 2'b00, '0, "R7");
      lit_check(1'b1, 18'h00D02, "R7");
      step(1'b0, ON, 1'b0, 1'b1, 6'd5, 2'b00, '0, "R7");
      lit_check(1'b1, 18'h00D03, "R7");
      step(1'b0, ON, 1'b0, 1'b1, 6'd6, 2'b00, '0, "R7");
      for (int k = 0; k < 3; k++) step(1'b0, ON, 1'b1, 1'b1, '0, 2'b00, '0, "R7");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, '0, "R7");

      // R8: interleaved write burst from 9 -> 9,8,11,10
      burst_ilv = 1'b1;
      step(1'b0, ON, 1'b0, 1'b0, 6'd9, 2'b00, '0, "R8");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h00E00, "R8");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h00E01, "R8");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h00E02, "R8");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h00E03, "R8");
      step(1'b0, ON, 1'b0, 1'b1, 6'd11, 2'b00, '0, "R8");
      lit_check(1'b1, 18'h00E02, "R8");
      step(1'b0, ON, 1'b0, 1'b1, 6'd8, 2'b00, '0, "R8");
      lit_check(1'b1, 18'h00E01, "R8");
      step(1'b0, ON, 1'b0, 1'b1, 6'd10, 2'b00, '0, "R8");
      for (int k = 0; k < 3; k++) step(1'b0, ON, 1'b1, 1'b1, '0, 2'b00, '0, "R8");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, '0, "R8");
      burst_ilv = 1'b0;

      // R5: stall during a read and during a pending write
      step(1'b0, ON, 1'b0, 1'b1, 6'd30, 2'b00, '0, "R5");
      for (int k = 0; k < 3; k++) begin
         step(1'b1, ON, 1'b0, 1'b0, 6'd2, 2'b00, 18'h3C3C3, "R5");
         lit_check(1'b1, fdat(30), "R5");
      end
      step(1'b0, ON, 1'b0, 1'b0, 6'd31, 2'b00, '0, "R5");
      for (int k = 0; k < 3; k++) step(1'b1, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h3FFFF, "R5");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h0F00F, "R5");
      step(1'b0, ON, 1'b0, 1'b1, 6'd31, 2'b00, '0, "R5");
      lit_check(1'b1, 18'h0F00F, "R5");

      // R9: output enable blocks the port but not writes
      out_en_n = 1'b1;
      step(1'b0, ON, 1'b0, 1'b1, 6'd12, 2'b00, '0, "R9");
      lit_check(1'b0, '0, "R9");
      step(1'b0, ON, 1'b0, 1'b0, 6'd12, 2'b00, '0, "R9");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h01212, "R9");
      out_en_n = 1'b0;
      step(1'b0, ON, 1'b0, 1'b1, 6'd12, 2'b00, '0, "R9");
      lit_check(1'b1, 18'h01212, "R9");

      // R4: only lane 1 written
      step(1'b0, ON, 1'b0, 1'b0, 6'd50, 2'b00, '0, "R4");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b01, 18'h3FFFF, "R4");
      step(1'b0, ON, 1'b0, 1'b1, 6'd50, 2'b00, '0, "R4");
      lit_check(1'b1, {9'h1FF, fdat(50)[8:0]}, "R4");

      // R10: sleep ignores commands and silences the port
      sleep = 1'b1;
      step(1'b0, ON, 1'b0, 1'b0, 6'd40, 2'b00, '0, "R10");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h3ABCD, "R10");
      step(1'b0, ON, 1'b0, 1'b1, 6'd40, 2'b00, '0, "R10");
      lit_check(1'b0, '0, "R10");
      sleep = 1'b0;
      step(1'b0, ON, 1'b0, 1'b1, 6'd40, 2'b00, '0, "R10");
      lit_check(1'b1, fdat(40), "R10");

      // R6: deselect by each chip select
      step(1'b0, ON, 1'b0, 1'b1, 6'd41, 2'b00, '0, "R6");
      step(1'b0, 3'b000, 1'b0, 1'b1, 6'd41, 2'b00, '0, "R6");
      lit_check(1'b0, '0, "R6");
      step(1'b0, 3'b011, 1'b0, 1'b0, 6'd41, 2'b00, '0, "R6");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, 18'h2BADA, "R6");
      step(1'b0, ON, 1'b0, 1'b1, 6'd41, 2'b00, '0, "R6");
      lit_check(1'b1, fdat(41), "R6");

      // R12: advance after deselect does nothing
      step(1'b0, OFF, 1'b0, 1'b0, 6'd41, 2'b00, '0, "R12");
      step(1'b0, ON, 1'b1, 1'b0, '0, 2'b00, 18'h31313, "R12");
      lit_check(1'b0, '0, "R12");
      step(1'b0, ON, 1'b1, 1'b1, '0, 2'b00, 18'h32323, "R12");
      lit_check(1'b0, '0, "R12");
      step(1'b0, ON, 1'b0, 1'b1, 6'd41, 2'b00, '0, "R12");
      lit_check(1'b1, fdat(41), "R12");
      step(1'b0, OFF, 1'b0, 1'b1, '0, 2'b00, '0, "R12");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule